// File: doc/BRIEF.md
# Serial Receiver with Tagged Receive Queue

This block turns an asynchronous serial line into a queue of characters. It watches the line on a 16x oversampling tick and finds the start of each frame. It then recovers 5 to 8 data bits, least significant first, and an optional parity bit, and checks the first stop bit. Each character enters a small receive queue together with its own parity-error tag. The reader therefore learns which byte was damaged, not only that some byte was.

The character size and parity settings come in as run-time inputs and are changed only between frames. Four sticky event flags record a stop-bit error, a parity mismatch, an arrival that found the queue full, and the queue reaching a programmable level. Software clears a flag by writing 1 to its bit. A single interrupt line combines the flags with a per-flag enable mask.

Top module: `serial_rx_tagq`

## Requirements
- R1: After reset the queue is empty (empty 1, full 0, count 0), busy is 0, every flag is 0 and the interrupt is 0.
- R2: char_sel_i picks 5, 6, 7 or 8 data bits (values 0..3). Bits arrive least significant first, and data_o holds the character zero-extended to 8 bits.
- R3: When par_en_i is 1, one parity bit follows the data. par_zero_i=0 counts ones and par_zero_i=1 counts zeros, over the data bits and the parity bit together. The total must be even when par_odd_i=0 and odd when par_odd_i=1. On a mismatch the entry's tag (perr_o) and flag bit 1 are set. With parity disabled the tag is 0.
- R4: A low level on the line that is high again when re-sampled 8 ticks after detection is ignored. No character is stored and busy returns to 0.
- R5: A first stop bit sampled low sets flag bit 0. The character is still stored.
- R6: The queue is first in, first out and holds DEPTH entries. A one-cycle rd_i pops the head, and count_o, empty_o and full_o track the occupancy.
- R7: A character that arrives while the queue is full is dropped, the stored entries and count are unchanged, and flag bit 2 is set.
- R8: Flag bit 3 is set whenever count_o is greater than or equal to thr_i.
- R9: A 1 in flag_clr_i clears that flag on the next clock. A 0 leaves it unchanged, and a flag whose event recurs in the same cycle stays set.
- R10: irq_o is 1 exactly when some flag bit is 1 and its irq_en_i bit is 1.
- R11: A one-cycle flush_i empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rx_i | input | 1 | Serial line, idle high |
| char_sel_i | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd total, 0 = even total |
| par_zero_i | input | 1 | 1 = count zeros, 0 = count ones |
| thr_i | input | 4 | Queue level for flag bit 3 |
| rd_i | input | 1 | Pop the queue head |
| flush_i | input | 1 | Empty the queue |
| irq_en_i | input | 4 | Per-flag interrupt enable |
| flag_clr_i | input | 4 | Write-one-to-clear flags |
| data_o | output | 8 | Head character |
| perr_o | output | 1 | Head parity-error tag |
| busy_o | output | 1 | Frame reception in progress |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| count_o | output | 4 | Queue occupancy |
| flags_o | output | 4 | Flags: 0 stop error, 1 parity, 2 overrun, 3 level |
| irq_o | output | 1 | Combined interrupt |

## Verification
A receiver that lands on the wrong bit count or sampling phase shows up at once in the next popped character, as shifted or truncated data. A wrong parity polarity or count sense flips perr_o and flag bit 1 on the first frame of that mode. Corrupted queue pointers show a few frames later, as characters popped out of order or a wrong count after overrun and flush. Each character size, each parity mode and each data pattern is checked when it is popped, directly after its frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FL_STOP = 0;
  localparam int unsigned FL_PAR  = 1;
  localparam int unsigned FL_OVR  = 2;
  localparam int unsigned FL_LVL  = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  typedef struct packed {
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
  import serial_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] char_sel_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       par_zero_i,
  output logic       push_o,
  output rx_entry_t  entry_o,
  output logic       stop_err_o,
  output logic       busy_o
);
  localparam int unsigned OSR     = 16;
  localparam int unsigned CNT_W   = $clog2(OSR);
  localparam int unsigned IDX_W   = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CHAR_W-1:0] shift_q;
  logic              perr_q, push_q, serr_q;
  logic [CHAR_W-1:0] data_al;
  logic [IDX_W-1:0]  last_idx;
  logic              exp_par;

  assign rx_s     = sync_q[1];
  assign last_idx = IDX_W'(char_sel_i) + IDX_W'(4);
  // bits were shifted in from the top; align the short characters down
  assign data_al  = shift_q >> (2'd3 - char_sel_i);
  // odd bit count is ~char_sel_i[0] (5 and 7)
  assign exp_par  = par_zero_i ? (~(~char_sel_i[0] ^ (^data_al)) ^ par_odd_i)
                               : ((^data_al) ^ par_odd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      perr_q  <= 1'b0;
      push_q  <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      push_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_s) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: if (cnt_q == HALF_M1) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            perr_q <= 1'b0;
            state_q <= rx_s ? ST_IDLE : ST_DATA;
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (cnt_q == FULL_M1) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[CHAR_W-1:1]};
            if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          ST_PAR: if (cnt_q == FULL_M1) begin
            cnt_q   <= '0;
            perr_q  <= (rx_s != exp_par);
            state_q <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_STOP: if (cnt_q == FULL_M1) begin
            cnt_q   <= '0;
            push_q  <= 1'b1;
            serr_q  <= ~rx_s;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign push_o       = push_q;
  assign entry_o.data = data_al;
  assign entry_o.perr = perr_q;
  assign stop_err_o   = serr_q;
  assign busy_o       = (state_q != ST_IDLE);

  a_r2_push_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_q |-> $past(state_q) == ST_STOP);
  a_r4_start_leaves_idle_only_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_IDLE && state_q == ST_START) |-> $past(!rx_s));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_entry_t     entry_i,
  input  logic          rd_i,
  input  logic          flush_i,
  output rx_entry_t     head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          overrun_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;
  logic            wr_ok, rd_ok;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CMAX);
  assign wr_ok     = push_i && !full_o && !flush_i;
  assign rd_ok     = rd_i && !empty_o && !flush_i;
  assign overrun_o = push_i && full_o;
  assign head_o    = mem_q[rp_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (wr_ok && !rd_ok)      cnt_q <= cnt_q + 1'b1;
      else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_ok && wp_q == AW'(g)) mem_q[g] <= entry_i;
    end
  end

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
  a_r7_full_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !rd_i && !flush_i) |=> $stable(cnt_q));
  a_r11_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  a_r6_empty_read_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !push_i) |=> empty_o);
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic [FLAG_W-1:0] en_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_q[g] <= 1'b0;
      else if (set_i[g]) flags_q[g] <= 1'b1;  // set wins over clear
      else if (clr_i[g]) flags_q[g] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  a_r9_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
  a_r9_no_spurious_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~flags_q & $past(flags_q & ~clr_i)) == '0));
endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THR_W = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        char_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              par_zero_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              rd_i,
  input  logic              flush_i,
  input  logic [FLAG_W-1:0] irq_en_i,
  input  logic [FLAG_W-1:0] flag_clr_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o,
  output logic              busy_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CW-1:0]     count_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  localparam int unsigned CMP_W = (CW > THR_W) ? CW : THR_W;

  logic              push, stop_err, overrun, lvl_hit;
  rx_entry_t         entry, head;
  logic [CW-1:0]     count;
  logic [FLAG_W-1:0] set_vec;

  serial_rx_deser u_deser (
    .clk_i, .rst_ni, .tick_i, .rx_i, .char_sel_i, .par_en_i, .par_odd_i, .par_zero_i,
    .push_o(push), .entry_o(entry), .stop_err_o(stop_err), .busy_o(busy_o)
  );

  serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .entry_i(entry), .rd_i, .flush_i,
    .head_o(head), .count_o(count), .empty_o(empty_o), .full_o(full_o),
    .overrun_o(overrun)
  );

  assign lvl_hit = (CMP_W'(count) >= CMP_W'(thr_i));

  always_comb begin
    set_vec          = '0;
    set_vec[FL_STOP] = push && stop_err;
    set_vec[FL_PAR]  = push && entry.perr;
    set_vec[FL_OVR]  = overrun;
    set_vec[FL_LVL]  = lvl_hit;
  end

  serial_rx_flags u_flags (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(flag_clr_i), .en_i(irq_en_i),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  assign data_o  = head.data;
  assign perr_o  = head.perr;
  assign count_o = count;

  a_r8_level_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CMP_W'(count_o) >= CMP_W'(thr_i)) |=> flags_o[FL_LVL]);
  a_r7_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full_o) |=> flags_o[FL_OVR]);
  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);
endmodule

// File: tb/serial_rx_tagq_test.sv
`timescale 1ns/1ps
module serial_rx_tagq_test;
  localparam int DEPTH = 8;
  localparam int TDIV  = 2;
  localparam int BIT   = 16 * TDIV;

  logic clk_i = 0, rst_ni = 0, tick_i = 0, rx_i = 1;
  logic [1:0] char_sel_i = 2'd3;
  logic par_en_i = 0, par_odd_i = 0, par_zero_i = 0;
  logic [3:0] thr_i = 4'hF;
  logic rd_i = 0, flush_i = 0;
  logic [3:0] irq_en_i = 0, flag_clr_i = 0;
  logic [7:0] data_o;
  logic perr_o, busy_o, empty_o, full_o, irq_o;
  logic [3:0] count_o, flags_o;

  int checks = 0, fails = 0;
  logic [7:0] sent [DEPTH];

  serial_rx_tagq #(.DEPTH(DEPTH)) uut (.*);

  always #2 clk_i = ~clk_i;
  always @(negedge clk_i) tick_i <= ~tick_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // pm: 0 off, 1 even/ones, 2 odd/ones, 3 even/zeros, 4 odd/zeros
  task automatic set_cfg(int sel, int pm);
    @(negedge clk_i);
    char_sel_i = 2'(sel);
    par_en_i   = (pm != 0);
    par_odd_i  = (pm == 2 || pm == 4);
    par_zero_i = (pm >= 3);
  endtask

  task automatic send(logic [7:0] d, int n, int pm, bit bad_par, bit bad_stop);
    int ones, zeros, base;
    bit odd, p;
    ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    zeros = n - ones;
    odd = (pm == 2 || pm == 4);
    base = (pm >= 3) ? zeros + 1 : ones;
    p = ((base % 2) != int'(odd));
    @(negedge clk_i);
    rx_i = 0; cycles(BIT);
    for (int i = 0; i < n; i++) begin rx_i = d[i]; cycles(BIT); end
    if (pm != 0) begin rx_i = p ^ bad_par; cycles(BIT); end
    if (bad_stop) begin rx_i = 0; cycles(BIT * 3 / 4); end
    rx_i = 1; cycles(2 * BIT);
  endtask

  task automatic pop;
    @(negedge clk_i) rd_i = 1;
    @(negedge clk_i) rd_i = 0;
  endtask

  task automatic clr(logic [3:0] v);
    @(negedge clk_i) flag_clr_i = v;
    @(negedge clk_i) flag_clr_i = 0;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] pats [5];
    logic [7:0] d, m;
    cycles(5);
    rst_ni = 1;
    cycles(2);
    // R1
    check("R1 empty", empty_o, 1);
    check("R1 full", full_o, 0);
    check("R1 count", count_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 flags", flags_o, 0);
    check("R1 irq", irq_o, 0);

    // R2/R3 sweep over sizes, parity modes, patterns
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h37;
    for (int sel = 0; sel < 4; sel++) begin
      for (int pm = 0; pm < 5; pm++) begin
        set_cfg(sel, pm);
        m = 8'((1 << (sel + 5)) - 1);
        for (int k = 0; k < 6; k++) begin
          bit bad;
          d = (k < 5) ? pats[k] : 8'(sel * 37 + pm * 11);
          bad = (pm != 0) && (k == 5);
          send(d, sel + 5, pm, bad, 0);
          check("R6 count after frame", count_o, 1);
          check("R2 data", data_o, d & m);
          check("R3 tag", perr_o, bad);
          check("R3 parity flag", flags_o[1], bad);
          check("R5 no stop error", flags_o[0], 0);
          clr(4'hF);
          pop();
          check("R6 empty after pop", empty_o, 1);
        end
      end
    end

    // R4 glitch
    set_cfg(3, 0);
    @(negedge clk_i) rx_i = 0;
    cycles(8);
    rx_i = 1;
    cycles(2 * BIT);
    check("R4 glitch not stored", count_o, 0);
    check("R4 busy back low", busy_o, 0);

    // R5 stop error, character stored
    send(8'hC3, 8, 0, 0, 1);
    check("R5 stop flag", flags_o[0], 1);
    check("R5 char kept", data_o, 8'hC3);
    check("R5 count", count_o, 1);
    // R9 write-one-to-clear
    clr(4'b1110);
    check("R9 zero leaves flag", flags_o[0], 1);
    clr(4'b0001);
    check("R9 one clears flag", flags_o[0], 0);
    pop();

    // R6/R7 fill, overrun, order
    for (int i = 0; i < DEPTH; i++) begin
      sent[i] = 8'(i * 29 + 3);
      send(sent[i], 8, 0, 0, 0);
    end
    check("R6 full", full_o, 1);
    check("R6 count full", count_o, DEPTH);
    check("R7 no overrun yet", flags_o[2], 0);
    send(8'hEE, 8, 0, 0, 0);
    check("R7 overrun flag", flags_o[2], 1);
    check("R7 count unchanged", count_o, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 order", data_o, sent[i]);
      pop();
    end
    check("R7 dropped char absent", empty_o, 1);
    clr(4'hF);

    // R8/R10 level flag and interrupt
    @(negedge clk_i) thr_i = 4'd3; irq_en_i = 4'b1000;
    send(8'h11, 8, 0, 0, 0);
    send(8'h22, 8, 0, 0, 0);
    check("R8 below level", flags_o[3], 0);
    check("R10 irq low", irq_o, 0);
    send(8'h33, 8, 0, 0, 0);
    check("R8 level reached", flags_o[3], 1);
    check("R10 irq high", irq_o, 1);
    @(negedge clk_i) irq_en_i = 4'b0111;
    @(negedge clk_i);
    check("R10 masked", irq_o, 0);

    // R11 flush
    @(negedge clk_i) flush_i = 1;
    @(negedge clk_i) flush_i = 0;
    check("R11 flushed count", count_o, 0);
    check("R11 flushed empty", empty_o, 1);
    clr(4'b1000);
    check("R9 level flag cleared", flags_o[3], 0);
    @(negedge clk_i) thr_i = 4'd0;
    cycles(2);
    check("R9 level recurs stays set", flags_o[3], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule